// File: doc/BRIEF.md
# Memory Strobe Lane Decoder

This block takes one set of microcoded memory strobes (row strobe, column strobe, special-function strobe, transfer/output-enable strobe and write strobe) and spreads them over a two-bank, 64-bit memory array. Every output is active low. An output goes low only when the matching microcoded strobe is low and the chips on that line are the ones being accessed. The row strobe is split between two banks by a bank-select bit. The write and transfer strobes are split between even and odd banks by an even/odd bit. The column strobe is split into eight byte lanes by a byte select and an access width.

The access width sets how many column lanes open together: one, two, four or all eight. The high-order byte-select bits pick the group, and at full width the byte select has no effect. The decode is combinational. A parameter can add one output register stage, so the memory pins change cleanly on a clock edge.

Top module: `strobe_lane_decoder`

## Requirements
- R1: While reset is held, and until the first capture after reset is released, every output line is high (inactive), whatever the inputs are.
- R2: Row line 0 goes low only when the microcoded row strobe is low and bank select is 0. Row line 1 goes low only when the strobe is low and bank select is 1.
- R3: Access mode 2'b00 (byte): when the microcoded column strobe is low, only column lane `byte_sel` is low.
- R4: Access mode 2'b01 (halfword): when the column strobe is low, lanes 2k and 2k+1 are low, with k = `byte_sel[2:1]`. All other lanes stay high.
- R5: Access mode 2'b10 (word): when the column strobe is low, lanes 0 to 3 are low if `byte_sel[2]` is 0, and lanes 4 to 7 are low if it is 1.
- R6: Access mode 2'b11 (full width): when the column strobe is low, all eight lanes are low for every value of `byte_sel`.
- R7: The special-function output equals the microcoded special-function strobe.
- R8: Write line 0 goes low only when the microcoded write strobe is low and `even_odd` is 0. Write line 1 goes low only when the strobe is low and `even_odd` is 1.
- R9: Transfer line 0 goes low only when the microcoded transfer strobe is low and `even_odd` is 0. Transfer line 1 goes low only when the strobe is low and `even_odd` is 1.
- R10: A high (inactive) microcoded strobe holds every output line of its own kind high, for every select input.
- R11: With the default output register, the outputs show the inputs captured at a rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_ras_n | input | 1 | Microcoded row strobe, active low |
| mc_cas_n | input | 1 | Microcoded column strobe, active low |
| mc_dsf | input | 1 | Microcoded special-function strobe |
| mc_trg_n | input | 1 | Microcoded transfer/output-enable strobe, active low |
| mc_we_n | input | 1 | Microcoded write strobe, active low |
| bank_sel | input | 1 | Row bank select |
| even_odd | input | 1 | Even (0) / odd (1) bank select for write and transfer |
| byte_sel | input | 3 | Byte lane select |
| acc_mode | input | 2 | Access width: 00 byte, 01 halfword, 10 word, 11 full |
| ras_n | output | 2 | Per-bank row strobes |
| cas_n | output | 8 | Per-lane column strobes |
| dsf | output | 1 | Special-function strobe |
| trg_n | output | 2 | Per-bank transfer strobes |
| we_n | output | 2 | Per-bank write strobes |

## Verification
Bank gating and lane decoding act in the same cycle, because a single input word drives both. The risk is that one select leaks into the other path. The bench applies vectors where the row strobe picks one bank and the column strobe opens a halfword group, while the write strobe is parked inactive. It then swaps which strobes are active and which are parked. Each vector is judged on the whole output word at once, one edge after it is applied, against a model built from the requirement equations.

// File: rtl/strb_pkg.sv
package strb_pkg;
  typedef enum logic [1:0] {
    ACC_B8  = 2'b00,
    ACC_B16 = 2'b01,
    ACC_B32 = 2'b10,
    ACC_B64 = 2'b11
  } acc_mode_e;

  typedef logic [1:0] pair_n_t;

  localparam int unsigned DEF_LANES = 8;
endpackage

// File: rtl/strb_pair_gate.sv
module strb_pair_gate (
  input  logic              strobe_n,
  input  logic              side,
  output strb_pkg::pair_n_t line_n
);
  always_comb begin
    line_n[0] = strobe_n | side;
    line_n[1] = strobe_n | ~side;
  end
endmodule

// File: rtl/strb_lane_decode.sv
module strb_lane_decode #(
  parameter int unsigned LANES = 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic                  cas_n,
  input  logic [SEL_W-1:0]      sel,
  input  strb_pkg::acc_mode_e   mode,
  output logic [LANES-1:0]      lane_n
);
  logic [$clog2(SEL_W+1)-1:0] grain;

  always_comb begin
    if (mode == strb_pkg::ACC_B64) grain = SEL_W[$clog2(SEL_W+1)-1:0];
    else                           grain = $clog2(SEL_W+1)'(mode);
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam logic [SEL_W-1:0] IDX = SEL_W'(gi);
    always_comb begin
      lane_n[gi] = cas_n | ((IDX >> grain) != (sel >> grain));
    end
  end
endmodule

// File: rtl/strb_out_stage.sv
module strb_out_stage #(
  parameter int unsigned W       = 15,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_nxt;
    logic [W-1:0] q_r;
    always_comb q_nxt = d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '1;
      else        q_r <= q_nxt;
    end
    assign q = q_r;
  end else begin : g_pass
    logic unused_ok;
    assign unused_ok = &{1'b0, clk, rst_n};
    assign q = d;
  end
endmodule

// File: rtl/strobe_lane_decoder.sv
module strobe_lane_decoder #(
  parameter int unsigned LANES   = strb_pkg::DEF_LANES,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned OUT_W  = 2 + LANES + 1 + 2 + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_ras_n,
  input  logic             mc_cas_n,
  input  logic             mc_dsf,
  input  logic             mc_trg_n,
  input  logic             mc_we_n,
  input  logic             bank_sel,
  input  logic             even_odd,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic [1:0]       acc_mode,
  output logic [1:0]       ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             dsf,
  output logic [1:0]       trg_n,
  output logic [1:0]       we_n
);
  import strb_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  pair_n_t          ras_d, trg_d, we_d;
  logic [LANES-1:0] cas_d;
  acc_mode_e        mode_e;

  assign mode_e = acc_mode_e'(acc_mode);

  strb_pair_gate i_ras_gate (.strobe_n(mc_ras_n), .side(bank_sel), .line_n(ras_d));
  strb_pair_gate i_we_gate  (.strobe_n(mc_we_n),  .side(even_odd), .line_n(we_d));
  strb_pair_gate i_trg_gate (.strobe_n(mc_trg_n), .side(even_odd), .line_n(trg_d));

  strb_lane_decode #(.LANES(LANES)) i_lane (
    .cas_n (mc_cas_n),
    .sel   (byte_sel),
    .mode  (mode_e),
    .lane_n(cas_d)
  );

  logic [OUT_W-1:0] pins_d, pins_q;
  assign pins_d = {ras_d, cas_d, mc_dsf, trg_d, we_d};

  strb_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) i_out (
    .clk  (clk),
    .rst_n(rst_s2),
    .d    (pins_d),
    .q    (pins_q)
  );

  assign {ras_n, cas_n, dsf, trg_n, we_n} = pins_q;

  // ---- assertions next to the decode they guard ----
  p_ras_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot0(~ras_d));
  p_ras_follow_r2: assert property (@(posedge clk) disable iff (!rst_s2)
    !mc_ras_n |-> (ras_d[bank_sel] == 1'b0));
  p_cas_count_r3: assert property (@(posedge clk) disable iff (!rst_s2)
    !mc_cas_n |-> ($countones(~cas_d) ==
      ((acc_mode == 2'b11) ? LANES : (1 << acc_mode))));
  p_cas_hit_r3: assert property (@(posedge clk) disable iff (!rst_s2)
    !mc_cas_n |-> (cas_d[byte_sel] == 1'b0));
  p_we_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot0(~we_d));
  p_trg_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot0(~trg_d));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_s2)
    mc_cas_n |-> (&cas_d));
  if (REG_OUT) begin : g_reg_chk
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_s2)
      $past(rst_s2) |-> ({ras_n, cas_n, dsf, trg_n, we_n} == $past(pins_d)));
  end
endmodule

// File: tb/test_strobe_lane_decoder.sv
`timescale 1ns/1ps
module test_strobe_lane_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic mc_ras_n, mc_cas_n, mc_dsf, mc_trg_n, mc_we_n, bank_sel, even_odd;
  logic [2:0] byte_sel;
  logic [1:0] acc_mode;
  logic [1:0] ras_n, trg_n, we_n;
  logic [7:0] cas_n;
  logic dsf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strobe_lane_decoder i_strobe_lane_decoder (
    .clk(clk), .rst_n(rst_n), .mc_ras_n(mc_ras_n), .mc_cas_n(mc_cas_n),
    .mc_dsf(mc_dsf), .mc_trg_n(mc_trg_n), .mc_we_n(mc_we_n),
    .bank_sel(bank_sel), .even_odd(even_odd), .byte_sel(byte_sel),
    .acc_mode(acc_mode), .ras_n(ras_n), .cas_n(cas_n), .dsf(dsf),
    .trg_n(trg_n), .we_n(we_n));

  function automatic logic [14:0] model();
    logic [7:0] c;
    case (acc_mode)
      2'b00: c = ~(8'b0000_0001 << byte_sel);
      2'b01: c = ~(8'b0000_0011 << {byte_sel[2:1], 1'b0});
      2'b10: c = ~(8'b0000_1111 << {byte_sel[2], 2'b00});
      default: c = 8'h00;
    endcase
    c = c | {8{mc_cas_n}};
    return {mc_ras_n | ~bank_sel, mc_ras_n | bank_sel, c, mc_dsf,
            mc_trg_n | ~even_odd, mc_trg_n | even_odd,
            mc_we_n | ~even_odd, mc_we_n | even_odd};
  endfunction

  function automatic logic [14:0] pins();
    return {ras_n, cas_n, dsf, trg_n, we_n};
  endfunction

  task automatic chk(string req, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic r, logic c, logic d, logic t, logic w,
                       logic bs, logic eo, logic [2:0] sel, logic [1:0] m);
    @(negedge clk);
    {mc_ras_n, mc_cas_n, mc_dsf, mc_trg_n, mc_we_n} = {r, c, d, t, w};
    {bank_sel, even_odd, byte_sel, acc_mode} = {bs, eo, sel, m};
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();  // R1
    rst_n = 1'b0;
    {mc_ras_n, mc_cas_n, mc_dsf, mc_trg_n, mc_we_n} = 5'b00000;
    {bank_sel, even_odd, byte_sel, acc_mode} = 7'b0;
    repeat (3) @(posedge clk);
    #2 chk("R1 reset", pins(), 15'h7fff);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 chk("R1 release", pins(), 15'h7fff);
    repeat (3) @(posedge clk);
  endtask

  task automatic t_ras();  // R2
    for (int b = 0; b < 2; b++) begin
      drive(0, 1, 0, 1, 1, b[0], 0, 3'd0, 2'b00); settle();
      chk("R2 ras bank", pins(), model());
    end
  endtask

  task automatic t_byte();  // R3
    for (int s = 0; s < 8; s++) begin
      drive(1, 0, 0, 1, 1, 0, 0, 3'(s), 2'b00); settle();
      chk("R3 byte lane", pins(), model());
    end
  endtask

  task automatic t_half();  // R4
    for (int s = 0; s < 8; s++) begin
      drive(1, 0, 0, 1, 1, 0, 0, 3'(s), 2'b01); settle();
      chk("R4 halfword lanes", pins(), model());
    end
  endtask

  task automatic t_word();  // R5
    for (int s = 0; s < 8; s += 3) begin
      drive(1, 0, 0, 1, 1, 0, 0, 3'(s), 2'b10); settle();
      chk("R5 word lanes", pins(), model());
    end
  endtask

  task automatic t_full();  // R6
    for (int s = 0; s < 8; s++) begin
      drive(1, 0, 0, 1, 1, 0, 0, 3'(s), 2'b11); settle();
      chk("R6 full width", {ras_n, cas_n, dsf, trg_n, we_n},
          {2'b11, 8'h00, 1'b0, 4'hf});
    end
  endtask

  task automatic t_dsf();  // R7
    for (int v = 0; v < 2; v++) begin
      drive(1, 1, v[0], 1, 1, 1, 1, 3'd5, 2'b10); settle();
      chk("R7 dsf", pins(), model());
    end
  endtask

  task automatic t_we();  // R8
    for (int e = 0; e < 2; e++) begin
      drive(1, 1, 0, 1, 0, 0, e[0], 3'd2, 2'b00); settle();
      chk("R8 write bank", pins(), model());
    end
  endtask

  task automatic t_trg();  // R9
    for (int e = 0; e < 2; e++) begin
      drive(1, 1, 0, 0, 1, 1, e[0], 3'd6, 2'b01); settle();
      chk("R9 transfer bank", pins(), model());
    end
  endtask

  task automatic t_idle();  // R10
    for (int k = 0; k < 4; k++) begin
      drive(1, 1, 1, 1, 1, k[0], k[1], 3'(k * 3), 2'(k)); settle();
      chk("R10 idle strobes", pins(), 15'h7fff);
    end
  endtask

  task automatic t_mixed();  // R2 R4 R8 R10 in one cycle
    drive(0, 0, 0, 1, 1, 1, 1, 3'd3, 2'b01); settle();
    chk("R4 mixed row+column", pins(), model());
    drive(1, 0, 1, 0, 0, 0, 1, 3'd7, 2'b00); settle();
    chk("R8 mixed column+write", pins(), model());
  endtask

  task automatic t_latency();  // R11
    logic [14:0] prev;
    drive(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'b00); settle();
    prev = model();
    drive(0, 0, 1, 1, 1, 1, 1, 3'd6, 2'b10);
    #1 chk("R11 holds before edge", pins(), prev);
    settle();
    chk("R11 after edge", pins(), model());
  endtask

  initial begin
    t_reset();
    t_ras();
    t_byte();
    t_half();
    t_word();
    t_full();
    t_dsf();
    t_we();
    t_trg();
    t_idle();
    t_mixed();
    t_latency();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule